// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup Engine

This block turns a (process id, virtual page number) pair into a physical frame number using an inverted page table. The table has one slot per physical frame. Each slot records which process owns the frame and which virtual page it holds, so the frame number of a translation is simply the position of the slot that matches. Because the table is indexed by frame and not by page, a lookup has to search for its key. A fold of the page number picks the slot where the search starts, and a chain of link fields then leads through the slots whose pages fold to the same value.

A lookup is offered on a valid/ready request port. Once a request is accepted the engine goes busy: it examines one slot per clock, following links, until a slot matches, a slot ends the chain, or as many slots as there are frames have been examined without success. The result then appears for a single cycle with either a hit and the frame number, or a fault. Software fills and clears slots through a one-slot-per-cycle write port that sets every field of a slot, the chain link included.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is asserted and after it is released, every slot is invalid, `req_ready` is 1 and `resp_valid` is 0; a lookup issued after a reset faults even if slots were written before it.
- R2: Each accepted request produces exactly one `resp_valid` pulse of one cycle, during which exactly one of `resp_hit` and `resp_fault` is 1; on a hit `resp_frame` is the index of the matching slot, and on a fault it is 0.
- R3: The first slot examined is `(vpn[7:4] ^ vpn[3:0])` with the default widths (upper half of the page number XOR lower half, cut to the frame-index width); a match there gives `resp_valid` one cycle after the accepting edge.
- R4: A slot matches only if its valid bit is 1 and both its process id and its page number equal the request's; a slot with the right page but another process id does not match.
- R5: A slot that does not match and has its link-enable bit set sends the search to the slot named by its link field; each examined slot costs one cycle, so a match at the n-th slot gives `resp_valid` n cycles after the accepting edge; the link of an invalid slot is still followed.
- R6: `req_ready` is 1 only while the engine is idle: it falls after the accepting edge and rises again in the cycle after the `resp_valid` pulse; a request held while `req_ready` is 0 is not taken until `req_ready` returns.
- R7: If FRAMES slots (16 by default) have been examined without a match, the lookup ends with a fault even when the chain goes on, so a looping chain faults after FRAMES cycles.
- R8: A slot that does not match and has its link-enable bit clear ends the search with a fault.
- R9: With `wr_en` set at a clock edge, slot `wr_idx` takes the valid bit, process id, page number, link-enable bit and link from the write port, and lookups accepted afterwards see the new contents; writing a valid bit of 0 removes a translation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and taking a request |
| req_pid | input | PID_W (4) | Process id of the request |
| req_vpn | input | VPN_W (8) | Virtual page number of the request |
| resp_valid | output | 1 | Result present for one cycle |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | No translation found |
| resp_frame | output | IDX_W (4) | Frame number on a hit, 0 otherwise |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | IDX_W (4) | Slot (frame) to write |
| wr_valid | input | 1 | New valid bit |
| wr_pid | input | PID_W (4) | New process id |
| wr_vpn | input | VPN_W (8) | New page number |
| wr_link_en | input | 1 | New link-enable bit |
| wr_link | input | IDX_W (4) | New link to the next slot of the chain |

## Verification
Lookups are tried against an empty table, against a translation sitting in its own start slot, and against three pages that fold to the same slot and are chained one after another, so that the latency separates a match found at the first, second or third slot. Keys that agree on the page but not the process id tell a full-key compare from a page-only compare. A chain closed into a loop, with and without an invalid slot inside it, distinguishes the frame-count limit from the end-of-chain stop and shows that an invalid slot still forwards the walk. A request held high across several lookups and a reset between writes check the handshake and the cleared table.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WALK = 2'd1,
    S_DONE = 2'd2
  } walk_state_t;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] slot
);

  localparam int HALF = VPN_W / 2;
  localparam logic [VPN_W-1:0] LOW_MASK = {{(VPN_W-HALF){1'b0}}, {HALF{1'b1}}};

  // upper half XOR lower half, cut to the index width
  function automatic logic [IDX_W-1:0] fold_vpn(input logic [VPN_W-1:0] v);
    logic [VPN_W-1:0] x;
    x = (v >> HALF) ^ (v & LOW_MASK);
    return IDX_W'(x);
  endfunction

  assign slot = fold_vpn(vpn);

endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int FRAMES = 16,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_link_en,
  input  logic [IDX_W-1:0] wr_link,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic             rd_link_en,
  output logic [IDX_W-1:0] rd_link
);

  logic             slot_valid   [FRAMES];
  logic [PID_W-1:0] slot_pid     [FRAMES];
  logic [VPN_W-1:0] slot_vpn     [FRAMES];
  logic             slot_link_en [FRAMES];
  logic [IDX_W-1:0] slot_link    [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[g]   <= 1'b0;
        slot_pid[g]     <= '0;
        slot_vpn[g]     <= '0;
        slot_link_en[g] <= 1'b0;
        slot_link[g]    <= '0;
      end else if (sel) begin
        slot_valid[g]   <= wr_valid;
        slot_pid[g]     <= wr_pid;
        slot_vpn[g]     <= wr_vpn;
        slot_link_en[g] <= wr_link_en;
        slot_link[g]    <= wr_link;
      end
    end
  end

  assign rd_valid   = slot_valid[rd_idx];
  assign rd_pid     = slot_pid[rd_idx];
  assign rd_vpn     = slot_vpn[rd_idx];
  assign rd_link_en = slot_link_en[rd_idx];
  assign rd_link    = slot_link[rd_idx];

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [IDX_W-1:0] start_slot,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic             rd_link_en,
  input  logic [IDX_W-1:0] rd_link,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [IDX_W-1:0] resp_frame,
  output logic             start_evt,
  output logic             step_evt,
  output logic             match_evt,
  output logic             end_evt,
  output logic             limit_evt
);

  localparam int CNT_W = $clog2(FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FRAMES - 1);

  walk_state_t      state;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] steps;
  logic [PID_W-1:0] key_pid;
  logic [VPN_W-1:0] key_vpn;
  logic             r_hit;
  logic [IDX_W-1:0] r_frame;
  logic             key_match;
  logic             at_limit;

  function automatic logic slot_matches(input logic v, input logic [PID_W-1:0] sp,
                                        input logic [VPN_W-1:0] sv,
                                        input logic [PID_W-1:0] kp,
                                        input logic [VPN_W-1:0] kv);
    return v && (sp == kp) && (sv == kv);
  endfunction

  assign rd_idx    = cur_idx;
  assign key_match = slot_matches(rd_valid, rd_pid, rd_vpn, key_pid, key_vpn);
  assign at_limit  = (steps == LAST_STEP);

  assign req_ready = (state == S_IDLE);
  assign start_evt = req_valid && req_ready;
  assign step_evt  = (state == S_WALK);
  assign match_evt = step_evt && key_match;
  assign limit_evt = step_evt && !key_match && at_limit;
  assign end_evt   = step_evt && !key_match && !at_limit && !rd_link_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_idx <= '0;
      steps   <= '0;
      key_pid <= '0;
      key_vpn <= '0;
      r_hit   <= 1'b0;
      r_frame <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start_evt) begin
            key_pid <= req_pid;
            key_vpn <= req_vpn;
            cur_idx <= start_slot;
            steps   <= '0;
            state   <= S_WALK;
          end
        end
        S_WALK: begin
          if (match_evt) begin
            r_hit   <= 1'b1;
            r_frame <= cur_idx;
            state   <= S_DONE;
          end else if (end_evt || limit_evt) begin
            r_hit   <= 1'b0;
            r_frame <= '0;
            state   <= S_DONE;
          end else begin
            cur_idx <= rd_link;
            steps   <= steps + CNT_W'(1);
          end
        end
        S_DONE: begin
          state <= S_IDLE;
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign resp_valid = (state == S_DONE);
  assign resp_hit   = resp_valid && r_hit;
  assign resp_fault = resp_valid && !r_hit;
  assign resp_frame = resp_valid ? r_frame : '0;

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAMES = 16,
  parameter int PID_W  = 4,
  parameter int VPN_W  = 8,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_fault,
  output logic [IDX_W-1:0] resp_frame,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_link_en,
  input  logic [IDX_W-1:0] wr_link
);

  logic [IDX_W-1:0] start_slot;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;
  logic             rd_link_en;
  logic [IDX_W-1:0] rd_link;

  // named internal events, observed by the bound checker
  logic start_evt;
  logic step_evt;
  logic match_evt;
  logic end_evt;
  logic limit_evt;

  ipt_hash #(
    .VPN_W(VPN_W),
    .IDX_W(IDX_W)
  ) u_hash (
    .vpn  (req_vpn),
    .slot (start_slot)
  );

  ipt_table #(
    .FRAMES(FRAMES),
    .PID_W (PID_W),
    .VPN_W (VPN_W),
    .IDX_W (IDX_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_pid     (wr_pid),
    .wr_vpn     (wr_vpn),
    .wr_link_en (wr_link_en),
    .wr_link    (wr_link),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_pid     (rd_pid),
    .rd_vpn     (rd_vpn),
    .rd_link_en (rd_link_en),
    .rd_link    (rd_link)
  );

  ipt_walker #(
    .FRAMES(FRAMES),
    .PID_W (PID_W),
    .VPN_W (VPN_W),
    .IDX_W (IDX_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pid    (req_pid),
    .req_vpn    (req_vpn),
    .start_slot (start_slot),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_pid     (rd_pid),
    .rd_vpn     (rd_vpn),
    .rd_link_en (rd_link_en),
    .rd_link    (rd_link),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_fault (resp_fault),
    .resp_frame (resp_frame),
    .start_evt  (start_evt),
    .step_evt   (step_evt),
    .match_evt  (match_evt),
    .end_evt    (end_evt),
    .limit_evt  (limit_evt)
  );

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_fault,
  input logic start_evt,
  input logic step_evt,
  input logic match_evt,
  input logic end_evt,
  input logic limit_evt
);

  logic        busy;
  logic [15:0] walked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      walked <= '0;
    end else begin
      if (start_evt) begin
        busy   <= 1'b1;
        walked <= '0;
      end else if (step_evt) begin
        walked <= walked + 16'd1;
      end
      if (resp_valid) busy <= 1'b0;
    end
  end

  // R2: a result is either a hit or a fault, never both or neither
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit != resp_fault));

  // R2: a hit decided by the walk shows up as a hit next cycle
  p_match_gives_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (resp_valid && resp_hit));

  // R8: a chain end without a match gives a fault next cycle
  p_end_gives_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (resp_valid && resp_fault));

  // R7: reaching the walk limit gives a fault next cycle
  p_limit_gives_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    limit_evt |=> (resp_valid && resp_fault));

  // R7: never more than FRAMES slots examined per lookup
  p_walk_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> (int'(walked) < FRAMES));

  // R6: acceptance takes the engine busy
  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: the result is a one-cycle pulse followed by ready
  p_resp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));

  // R6: no result without an accepted request
  p_resp_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);

endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_fault (resp_fault),
  .start_evt  (start_evt),
  .step_evt   (step_evt),
  .match_evt  (match_evt),
  .end_evt    (end_evt),
  .limit_evt  (limit_evt)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb_top;

  localparam int NF = 16;
  localparam int PW = 4;
  localparam int VW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_pid = '0;
  logic [VW-1:0] req_vpn = '0;
  logic          resp_valid;
  logic          resp_hit;
  logic          resp_fault;
  logic [IW-1:0] resp_frame;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic          wr_valid = 1'b0;
  logic [PW-1:0] wr_pid = '0;
  logic [VW-1:0] wr_vpn = '0;
  logic          wr_link_en = 1'b0;
  logic [IW-1:0] wr_link = '0;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  ipt_lookup #(.FRAMES(NF), .PID_W(PW), .VPN_W(VW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid), .req_vpn(req_vpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_frame(resp_frame),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_pid(wr_pid),
    .wr_vpn(wr_vpn), .wr_link_en(wr_link_en), .wr_link(wr_link)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_val [NF];
  int m_pid [NF];
  int m_vpn [NF];
  int m_len [NF];
  int m_lnk [NF];
  bit m_busy = 0;
  int m_age  = 0;
  int m_n    = 0;
  bit m_hit  = 0;
  int m_frm  = 0;

  function automatic void model_walk(input int p, input int v,
                                     output bit h, output int fr, output int n);
    int idx;
    idx = ((v / 16) ^ (v % 16)) % NF;
    h = 0; fr = 0; n = 0;
    for (int s = 1; s <= NF; s++) begin
      n = s;
      if (m_val[idx] != 0 && m_pid[idx] == p && m_vpn[idx] == v) begin
        h = 1; fr = idx; return;
      end
      if (m_len[idx] == 0) return;
      idx = m_lnk[idx];
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        m_val[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; m_len[i] = 0; m_lnk[i] = 0;
      end
      m_busy = 0; m_age = 0;
    end else begin
      if (m_busy) begin
        if (m_age == m_n) m_busy = 0;
        else m_age++;
      end else if (req_valid) begin
        model_walk(int'(req_pid), int'(req_vpn), m_hit, m_frm, m_n);
        m_busy = 1; m_age = 0;
      end
      if (wr_en) begin
        m_val[wr_idx] = int'(wr_valid);
        m_pid[wr_idx] = int'(wr_pid);
        m_vpn[wr_idx] = int'(wr_vpn);
        m_len[wr_idx] = int'(wr_link_en);
        m_lnk[wr_idx] = int'(wr_link);
      end
    end
  end

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_rv;
      exp_rv = m_busy && (m_age == m_n);
      chk(req_ready == !m_busy, "R6 model ready", int'(req_ready), int'(!m_busy));
      chk(resp_valid == exp_rv, "R6 model resp_valid", int'(resp_valid), int'(exp_rv));
      if (exp_rv) begin
        chk(resp_hit == m_hit, "R2 model hit", int'(resp_hit), int'(m_hit));
        chk(resp_fault == !m_hit, "R2 model fault", int'(resp_fault), int'(!m_hit));
        chk(int'(resp_frame) == (m_hit ? m_frm : 0), "R2 model frame",
            int'(resp_frame), m_hit ? m_frm : 0);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input int idx, input bit v, input int p, input int vp,
                     input bit le, input int lk);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v; wr_pid = PW'(p);
    wr_vpn = VW'(vp); wr_link_en = le; wr_link = IW'(lk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input int p, input int vp, input bit eh, input int ef,
                        input int elat, input string tag);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_pid = PW'(p); req_vpn = VW'(vp); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(resp_hit == eh, {tag, " hit"}, int'(resp_hit), int'(eh));
    chk(resp_fault == !eh, {tag, " fault"}, int'(resp_fault), int'(!eh));
    if (eh) chk(int'(resp_frame) == ef, {tag, " frame"}, int'(resp_frame), ef);
    chk(lat == elat, {tag, " latency"}, lat, elat);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1 no result in reset", int'(resp_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R8: empty table, start slot 0 has no link
    lookup(2, 8'h00, 0, 0, 1, "R8 empty table");

    // R3 / R9: page 0x35 folds to slot 6
    put(6, 1, 2, 8'h35, 0, 0);
    lookup(2, 8'h35, 1, 6, 1, "R3 start slot hit");
    // R4: same page, other process
    lookup(3, 8'h35, 0, 0, 1, "R4 pid mismatch");
    // R3: page 0xA4 folds to slot 14
    put(14, 1, 5, 8'hA4, 0, 0);
    lookup(5, 8'hA4, 1, 14, 1, "R3 second start slot");
    lookup(4, 8'hA4, 0, 0, 1, "R4 pid mismatch slot 14");

    // R5: chain 6 -> 9 -> 12, pages 0x53 and 0x60 also fold to 6
    put(9, 1, 2, 8'h53, 0, 0);
    put(6, 1, 2, 8'h35, 1, 9);
    lookup(2, 8'h53, 1, 9, 2, "R5 second in chain");
    put(12, 1, 2, 8'h60, 0, 0);
    put(9, 1, 2, 8'h53, 1, 12);
    lookup(2, 8'h60, 1, 12, 3, "R5 third in chain");
    // R4: right pid, page 0x71 folds to 6 but is nowhere; R8 chain end
    lookup(2, 8'h71, 0, 0, 3, "R8 end of chain");

    // R7: close the chain into a loop
    put(12, 1, 2, 8'h60, 1, 6);
    lookup(2, 8'h71, 0, 0, NF, "R7 loop limit");
    lookup(2, 8'h35, 1, 6, 1, "R7 hit inside loop");

    // R5 / R9: invalidate slot 9, keep its link
    put(9, 0, 2, 8'h53, 1, 12);
    lookup(2, 8'h53, 0, 0, NF, "R9 invalidated entry");
    lookup(2, 8'h60, 1, 12, 3, "R5 link through invalid slot");

    // R6: request held high across several lookups
    @(negedge clk);
    req_pid = 4'd5; req_vpn = 8'hA4; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R6 idle after burst", int'(req_ready), 1);

    // R1: reset clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(2, 8'h35, 0, 0, 1, "R1 table cleared");
    lookup(5, 8'hA4, 0, 0, 1, "R1 table cleared slot 14");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule